// File: doc/BRIEF.md
# FPU Sticky Status Flag Unit

This block keeps the sticky exception flags of a floating-point control/status register and decides when a floating-point exception must be requested. Each time the floating-point unit presents a result, it also presents a status vector that names the condition it hit: nine separate invalid-operation causes, plus overflow, underflow, divide-by-zero and inexact. The block folds that vector into eight flags. It ORs them into the register and, while exceptions are enabled, raises a one-cycle request carrying the PC of the instruction that produced the result.

Software owns the register through a whole-word write port. The write loads the enable bit and all eight flags together, and it is the only way to clear a flag. The arithmetic datapath and the vectoring of the exception are outside this block.

Top module: `fpu_flag_accum`

## Requirements
- R1: After reset `csr_o`, `exc_req_o` and `exc_pc_o` are all zero.
- R2: While `csr_o[0]` (exception enable) is 0, a result strobe changes no flag and raises no request.
- R3: `csr_o[1]` (invalid) is set by a result strobe with any of `status_i[8:0]` set. Those nine status bits are, in order from bit 0: signalling NaN, quiet NaN, inf-inf, inf/inf, 0/0, inf*0, bad conversion, bad compare and bad square root.
- R4: `csr_o[2]` (signalling NaN) is set by `status_i[0]`, and `csr_o[3]` (quiet NaN) is set by `status_i[1]`.
- R5: `csr_o[6]` (infinity) is set by `status_i[2]` or `status_i[3]`, and by no other bit.
- R6: `status_i[9]` sets `csr_o[4]` (overflow), `status_i[10]` sets `csr_o[5]` (underflow), `status_i[11]` sets `csr_o[7]` (divide-by-zero) and `status_i[12]` sets `csr_o[8]` (inexact).
- R7: Flags are sticky. Without a write, a flag that is set stays set through later strobes and idle cycles.
- R8: With `csr_we_i` high, `csr_o` equals `csr_wdata_i` after the edge, even when a strobe would set flags in the same cycle.
- R9: One cycle after a strobe with the enable set, `exc_req_o` is high when the old flags ORed with the new causes are nonzero. At that point `exc_pc_o` equals the `insn_pc_i` of that strobe. `exc_pc_o` is otherwise held.
- R10: `exc_req_o` is a one-cycle pulse: it is low in any cycle that does not follow a strobe.
- R11: A write in the same cycle as a strobe does not change the request decision. The decision uses the enable bit and flags from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| res_valid_i | input | 1 | Result strobe from the floating-point unit |
| status_i | input | 13 | Per-result cause vector (R3 to R6 give the bits) |
| insn_pc_i | input | PC_W | PC of the instruction that produced the result |
| csr_we_i | input | 1 | Software write of the whole register |
| csr_wdata_i | input | 9 | Write data: bit 0 enable, bits 8:1 flags |
| csr_o | output | 9 | Register value: bit 0 enable, bits 8:1 flags |
| exc_req_o | output | 1 | Exception request pulse |
| exc_pc_o | output | PC_W | PC reported with the request |

## Verification
A software write and a result strobe can land in the same cycle. The write must win the register, while the request must still follow the state from before the write. The bench provokes this directly, with a clearing write beside a divide-by-zero strobe. It also provokes it randomly, with writes interleaved among random strobes. A behavioural model applies the write-over-set priority and the request rule separately and is compared against the outputs every clock.

// File: rtl/fpu_flag_pkg.sv
package fpu_flag_pkg;
  localparam int STAT_W = 13;
  localparam int CSR_W  = 9;
  localparam int NFLAG  = CSR_W - 1;

  // status vector bit positions
  localparam int ST_SNAN = 0;
  localparam int ST_QNAN = 1;
  localparam int ST_ISI  = 2;
  localparam int ST_IDI  = 3;
  localparam int ST_ZDZ  = 4;
  localparam int ST_IMZ  = 5;
  localparam int ST_CVI  = 6;
  localparam int ST_CMP  = 7;
  localparam int ST_SQRT = 8;
  localparam int ST_OVF  = 9;
  localparam int ST_UNF  = 10;
  localparam int ST_DZ   = 11;
  localparam int ST_IX   = 12;
  localparam int N_INV   = ST_SQRT - ST_SNAN + 1;

  localparam int C_EN = 0;

  // packs to csr[8:1], inv at lsb
  typedef struct packed {
    logic ix;
    logic dz;
    logic inf;
    logic unf;
    logic ovf;
    logic qnan;
    logic snan;
    logic inv;
  } flags_t;
endpackage

// File: rtl/fpu_cause_decode.sv
module fpu_cause_decode
  import fpu_flag_pkg::*;
(
  input  logic [STAT_W-1:0] status_i,
  output flags_t            flags_o
);
  logic [N_INV-1:0] inv_hits;

  genvar g;
  generate
    for (g = 0; g < N_INV; g++) begin : g_inv
      assign inv_hits[g] = status_i[ST_SNAN + g];
    end
  endgenerate

  always_comb begin
    flags_o      = '0;
    flags_o.inv  = |inv_hits;
    flags_o.snan = status_i[ST_SNAN];
    flags_o.qnan = status_i[ST_QNAN];
    flags_o.inf  = status_i[ST_ISI] | status_i[ST_IDI];
    flags_o.ovf  = status_i[ST_OVF];
    flags_o.unf  = status_i[ST_UNF];
    flags_o.dz   = status_i[ST_DZ];
    flags_o.ix   = status_i[ST_IX];
  end
endmodule

// File: rtl/fpu_flag_reg.sv
module fpu_flag_reg
  import fpu_flag_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_en_i,
  input  flags_t           set_i,
  input  logic             we_i,
  input  logic [CSR_W-1:0] wdata_i,
  output logic             en_o,
  output flags_t           flags_o
);
  logic   en_q;
  flags_t flags_q;

  // software write wins over a same-cycle set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      flags_q <= '0;
    end else if (we_i) begin
      en_q    <= wdata_i[C_EN];
      flags_q <= flags_t'(wdata_i[CSR_W-1:1]);
    end else if (set_en_i) begin
      flags_q <= flags_q | set_i;
    end
  end

  assign en_o    = en_q;
  assign flags_o = flags_q;
endmodule

// File: rtl/fpu_exc_gen.sv
module fpu_exc_gen #(
  parameter int PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fire_i,
  input  logic [PC_W-1:0] pc_i,
  output logic            req_o,
  output logic [PC_W-1:0] pc_o
);
  logic            req_q;
  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      pc_q  <= '0;
    end else begin
      req_q <= fire_i;
      if (fire_i) pc_q <= pc_i;
    end
  end

  assign req_o = req_q;
  assign pc_o  = pc_q;
endmodule

// File: rtl/fpu_flag_accum.sv
module fpu_flag_accum
  import fpu_flag_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              res_valid_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic [PC_W-1:0]   insn_pc_i,
  input  logic              csr_we_i,
  input  logic [CSR_W-1:0]  csr_wdata_i,
  output logic [CSR_W-1:0]  csr_o,
  output logic              exc_req_o,
  output logic [PC_W-1:0]   exc_pc_o
);
  flags_t new_flags, cur_flags, merged;
  logic   en, accept, fire;

  fpu_cause_decode u_dec (
    .status_i (status_i),
    .flags_o  (new_flags)
  );

  assign accept = res_valid_i & en;
  assign merged = cur_flags | new_flags;
  // decision uses pre-write state
  assign fire   = accept & (|merged);

  fpu_flag_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_en_i(accept),
    .set_i   (new_flags),
    .we_i    (csr_we_i),
    .wdata_i (csr_wdata_i),
    .en_o    (en),
    .flags_o (cur_flags)
  );

  fpu_exc_gen #(.PC_W(PC_W)) u_exc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fire_i(fire),
    .pc_i  (insn_pc_i),
    .req_o (exc_req_o),
    .pc_o  (exc_pc_o)
  );

  assign csr_o = {cur_flags, en};
endmodule

// File: rtl/fpu_flag_accum_chk.sv
module fpu_flag_accum_chk #(
  parameter int PC_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            res_valid_i,
  input logic [12:0]     status_i,
  input logic [PC_W-1:0] insn_pc_i,
  input logic            csr_we_i,
  input logic [8:0]      csr_wdata_i,
  input logic [8:0]      csr_o,
  input logic            exc_req_o,
  input logic [PC_W-1:0] exc_pc_o
);
  always @(posedge clk_i) if (!rst_ni)
    a_r1_reset_clear: assert (csr_o == '0 && !exc_req_o && exc_pc_o == '0);

  a_r2_disabled_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && !csr_o[0] && !csr_we_i |=> csr_o == $past(csr_o) && !exc_req_o);

  a_r3_invalid_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && csr_o[0] && !csr_we_i && (|status_i[8:0]) |=> csr_o[1]);

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_we_i |=> (csr_o[8:1] & $past(csr_o[8:1])) == $past(csr_o[8:1]));

  a_r8_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_we_i |=> csr_o == $past(csr_wdata_i));

  a_r9_req_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && csr_o[0] && (|csr_o[8:1]) |=> exc_req_o && exc_pc_o == $past(insn_pc_i));

  a_r9_pc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |=> $stable(exc_pc_o));

  a_r10_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |=> !exc_req_o);
endmodule

bind fpu_flag_accum fpu_flag_accum_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/fpu_flag_accum_tb_top.sv
`timescale 1ns/1ps
module fpu_flag_accum_tb_top;
  localparam int PC_W = 32;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            res_valid_i = 1'b0;
  logic [12:0]     status_i = '0;
  logic [PC_W-1:0] insn_pc_i = '0;
  logic            csr_we_i = 1'b0;
  logic [8:0]      csr_wdata_i = '0;
  logic [8:0]      csr_o;
  logic            exc_req_o;
  logic [PC_W-1:0] exc_pc_o;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  fpu_flag_accum #(.PC_W(PC_W)) dut_i (.*);

  // expected flag word (csr bits 8:1) from a cause vector
  function automatic logic [7:0] exp_flags(logic [12:0] s);
    logic [7:0] f = '0;
    for (int k = 0; k < 9; k++) if (s[k]) f[0] = 1'b1;
    if (s[0]) f[1] = 1'b1;
    if (s[1]) f[2] = 1'b1;
    if (s[9]) f[3] = 1'b1;
    if (s[10]) f[4] = 1'b1;
    if (s[2] || s[3]) f[5] = 1'b1;
    if (s[11]) f[6] = 1'b1;
    if (s[12]) f[7] = 1'b1;
    return f;
  endfunction

  // behavioural reference
  logic [8:0]      m_csr;
  logic            m_req;
  logic [PC_W-1:0] m_pc;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_csr = '0; m_req = 1'b0; m_pc = '0;
    end else begin
      logic [8:0] old;
      logic [7:0] nf;
      old = m_csr;
      nf = exp_flags(status_i);
      m_req = 1'b0;
      if (res_valid_i && old[0] && ((old[8:1] | nf) != 0)) begin
        m_req = 1'b1;
        m_pc = insn_pc_i;
      end
      if (csr_we_i) m_csr = csr_wdata_i;
      else if (res_valid_i && old[0]) m_csr = {old[8:1] | nf, old[0]};
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  always @(negedge clk_i) if (cmp_on && rst_ni) begin
    chk("R7 model csr", 32'(csr_o), 32'(m_csr));
    chk("R10 model req", 32'(exc_req_o), 32'(m_req));
    chk("R9 model pc", exc_pc_o, m_pc);
  end

  // one stimulus cycle, then idle inputs, then sample at negedge
  task automatic step(bit v, logic [12:0] s, logic [31:0] pc, bit we, logic [8:0] wd);
    @(negedge clk_i);
    res_valid_i = v; status_i = s; insn_pc_i = pc; csr_we_i = we; csr_wdata_i = wd;
    @(posedge clk_i);
    #1;
    res_valid_i = 0; status_i = '0; csr_we_i = 0;
    @(negedge clk_i);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset csr", 32'(csr_o), 0);
    chk("R1 reset req", 32'(exc_req_o), 0);
    chk("R1 reset pc", exc_pc_o, 0);
    rst_ni = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk_i);

    step(1, 13'h1fff, 32'h100, 0, '0);
    chk("R2 disabled csr", 32'(csr_o), 0);
    chk("R2 disabled req", 32'(exc_req_o), 0);

    step(0, '0, '0, 1, 9'h001);
    chk("R8 write enable", 32'(csr_o), 32'h001);

    step(1, 13'h0001, 32'h204, 0, '0);
    chk("R3 R4 snan csr", 32'(csr_o), 32'h007);
    chk("R9 req", 32'(exc_req_o), 1);
    chk("R9 pc", exc_pc_o, 32'h204);

    @(negedge clk_i);
    chk("R10 pulse ends", 32'(exc_req_o), 0);
    chk("R9 pc held", exc_pc_o, 32'h204);

    step(0, '0, '0, 1, 9'h001);
    step(1, 13'h0004, 32'h300, 0, '0);
    chk("R5 isi csr", 32'(csr_o), 32'h043);

    step(0, '0, '0, 1, 9'h001);
    step(1, 13'h0008, 32'h304, 0, '0);
    chk("R5 idi csr", 32'(csr_o), 32'h043);

    step(0, '0, '0, 1, 9'h001);
    step(1, 13'h0002, 32'h308, 0, '0);
    chk("R4 qnan csr", 32'(csr_o), 32'h00b);

    step(0, '0, '0, 1, 9'h001);
    step(1, 13'h1e00, 32'h400, 0, '0);
    chk("R6 ovf unf dz ix csr", 32'(csr_o), 32'h1b1);

    step(1, 13'h0000, 32'h404, 0, '0);
    chk("R7 sticky csr", 32'(csr_o), 32'h1b1);
    chk("R9 sticky req", 32'(exc_req_o), 1);
    chk("R9 sticky pc", exc_pc_o, 32'h404);

    step(1, 13'h0800, 32'h500, 1, 9'h001);
    chk("R8 write beats set", 32'(csr_o), 32'h001);
    chk("R11 req from pre-write", 32'(exc_req_o), 1);
    chk("R11 pc", exc_pc_o, 32'h500);

    step(1, 13'h0000, 32'h504, 0, '0);
    chk("R9 no flags no req", 32'(exc_req_o), 0);
    chk("R9 pc held no req", exc_pc_o, 32'h500);

    step(1, 13'h0010, 32'h508, 1, 9'h000);
    chk("R11 disable write csr", 32'(csr_o), 32'h000);
    chk("R11 req before disable", 32'(exc_req_o), 1);

    for (int i = 0; i < 3000; i++) begin
      @(negedge clk_i);
      res_valid_i = ($urandom_range(0, 1) == 1);
      status_i    = 13'($urandom) & 13'($urandom);
      insn_pc_i   = $urandom;
      csr_we_i    = ($urandom_range(0, 7) == 0);
      csr_wdata_i = 9'($urandom) | 9'(($urandom_range(0, 3) != 0) ? 1 : 0);
    end
    @(negedge clk_i);
    res_valid_i = 0; csr_we_i = 0;
    repeat (2) @(negedge clk_i);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule